// File: doc/BRIEF.md
# Iterative Multiply/Divide Unit with Arithmetic Flags

This block performs one 32-bit integer multiplication or division at a time for a processor's execute stage. A request is accepted with `start_i` while the unit is idle. Operands, opcode and the range-exception enable are captured on that edge. The unit then iterates one bit per cycle: a shift-add multiplier, or a restoring divider working on operand magnitudes. It finishes with a single-cycle `done_o` pulse.

On completion the unit produces a 32-bit result, a write enable for the destination register, and carry and overflow flags. Their meaning depends on the opcode. It also requests a range exception when the captured enable is set and the opcode's exception condition holds. A division by zero is reported through carry and never writes the destination.

Opcode encoding on `op_i`: 2'b00 signed multiply, 2'b01 unsigned multiply, 2'b10 signed divide, 2'b11 unsigned divide.

Top module: `muldiv_unit`

## Requirements
- R1: Both multiplies (op 00 and 01) set `result_o` to the low 32 bits of the 64-bit product and pulse `wr_en_o` together with `done_o`.
- R2: For signed multiply (op 00), `ovf_o` is 1 exactly when the full signed product is outside -2^31 .. 2^31-1.
- R3: For signed multiply (op 00), `carry_o` is 1 exactly when the product of both operands read as unsigned values needs more than 32 bits.
- R4: Unsigned multiply (op 01) always clears `ovf_o` and never raises `range_exc_o`. It sets `carry_o` exactly when the unsigned product needs more than 32 bits.
- R5: For signed multiply, `range_exc_o` pulses with `done_o` exactly when the captured enable is 1 and `ovf_o` is 1.
- R6: Divides (op 10 and 11) with a non-zero divisor clear `carry_o`, write the quotient and pulse `wr_en_o`. The signed quotient truncates toward zero.
- R7: A divide by zero sets `carry_o`, does not pulse `wr_en_o`, and leaves `result_o` at its previous value.
- R8: Both divides always clear `ovf_o`.
- R9: For divides, `range_exc_o` pulses with `done_o` exactly when the captured enable is 1 and `carry_o` is 1.
- R10: Signed division of 0x80000000 by 0xFFFFFFFF returns 0x80000000 with carry and overflow clear.
- R11: `busy_o` is high from the cycle after acceptance until completion. `done_o` is high for exactly one cycle, 34 cycles after the accepting edge (operand width plus two). After reset, `busy_o`, `done_o`, `wr_en_o`, `range_exc_o`, `carry_o`, `ovf_o` and `result_o` are all 0.
- R12: `start_i` while `busy_o` is high is ignored; the running operation completes with its own operands.
- R13: The range-exception enable is sampled on the accepting edge; later changes of `ove_i` do not affect the running operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request a new operation (taken only while idle) |
| op_i | input | 2 | Opcode: 00 mul signed, 01 mul unsigned, 10 div signed, 11 div unsigned |
| a_i | input | 32 | First operand (multiplicand / dividend) |
| b_i | input | 32 | Second operand (multiplier / divisor) |
| ove_i | input | 1 | Range-exception enable, sampled with the request |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | 32 | Last written result |
| wr_en_o | output | 1 | Destination write strobe, coincident with done |
| carry_o | output | 1 | Carry flag of the last operation |
| ovf_o | output | 1 | Overflow flag of the last operation |
| range_exc_o | output | 1 | Range-exception request, coincident with done |

## Verification
The hardest cases to reach from the ports are a second request arriving mid-computation and a change of the exception enable after acceptance. Both depend on where in the 34-cycle window the stimulus falls. The bench places a conflicting request with different operands, and a toggled enable, several cycles into a running operation, then confirms the result belongs to the first request. Divide by zero is run right after a successful write, so that a result left unchanged can be told apart from a rewritten one. The most-negative-by-minus-one quotient is driven directly.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;
  typedef enum logic [1:0] {
    OP_MULS = 2'b00,
    OP_MULU = 2'b01,
    OP_DIVS = 2'b10,
    OP_DIVU = 2'b11
  } md_op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } md_state_e;
endpackage

// File: rtl/muldiv_ctrl.sv
module muldiv_ctrl
  import muldiv_pkg::*;
#(
  parameter int unsigned STEPS = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic busy_o,
  output logic load_o,
  output logic step_o,
  output logic fin_o,
  output logic done_o
);
  localparam int unsigned CW = (STEPS > 1) ? $clog2(STEPS) : 1;
  localparam logic [CW-1:0] LAST = CW'(STEPS - 1);

  md_state_e state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic done_q, done_d;

  assign load_o = (state_q == ST_IDLE) && start_i;
  assign step_o = (state_q == ST_RUN);
  assign fin_o  = (state_q == ST_FIN);
  assign busy_o = (state_q != ST_IDLE);
  assign done_o = done_q;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    done_d  = 1'b0;
    unique case (state_q)
      ST_IDLE: if (start_i) begin
        state_d = ST_RUN;
        cnt_d   = '0;
      end
      ST_RUN: begin
        if (cnt_q == LAST) state_d = ST_FIN;
        else               cnt_d   = cnt_q + 1'b1;
      end
      ST_FIN: begin
        state_d = ST_IDLE;
        done_d  = 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      done_q  <= done_d;
    end
  end
endmodule

// File: rtl/muldiv_mul_engine.sv
module muldiv_mul_engine #(
  parameter int unsigned W = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load_i,
  input  logic           step_i,
  input  logic [W-1:0]   mcand_i,
  input  logic [W-1:0]   mplier_i,
  output logic [2*W-1:0] prod_o
);
  logic [W-1:0] hi_q, hi_d, lo_q, lo_d, mcand_q, mcand_d;
  logic [W:0]   sum;

  always_comb begin
    sum     = {1'b0, hi_q} + (lo_q[0] ? {1'b0, mcand_q} : '0);
    hi_d    = hi_q;
    lo_d    = lo_q;
    mcand_d = mcand_q;
    if (load_i) begin
      hi_d    = '0;
      lo_d    = mplier_i;
      mcand_d = mcand_i;
    end else if (step_i) begin
      hi_d = sum[W:1];
      lo_d = {sum[0], lo_q[W-1:1]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q    <= '0;
      lo_q    <= '0;
      mcand_q <= '0;
    end else if (load_i || step_i) begin
      hi_q    <= hi_d;
      lo_q    <= lo_d;
      mcand_q <= mcand_d;
    end
  end

  assign prod_o = {hi_q, lo_q};
endmodule

// File: rtl/muldiv_div_engine.sv
module muldiv_div_engine #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic         step_i,
  input  logic [W-1:0] dvd_i,
  input  logic [W-1:0] dvs_i,
  output logic [W-1:0] quo_o
);
  logic [W-1:0] rem_q, rem_d, quo_q, quo_d, dvs_q, dvs_d;
  logic [W:0]   shifted;
  logic [W-1:0] diff;
  logic         fits;

  always_comb begin
    shifted = {rem_q, quo_q[W-1]};
    fits    = (shifted >= {1'b0, dvs_q});
    diff    = shifted[W-1:0] - dvs_q;
    rem_d   = rem_q;
    quo_d   = quo_q;
    dvs_d   = dvs_q;
    if (load_i) begin
      rem_d = '0;
      quo_d = dvd_i;
      dvs_d = dvs_i;
    end else if (step_i) begin
      rem_d = fits ? diff : shifted[W-1:0];
      quo_d = {quo_q[W-2:0], fits};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
      quo_q <= '0;
      dvs_q <= '0;
    end else if (load_i || step_i) begin
      rem_q <= rem_d;
      quo_q <= quo_d;
      dvs_q <= dvs_d;
    end
  end

  assign quo_o = quo_q;
endmodule

// File: rtl/muldiv_unit.sv
module muldiv_unit
  import muldiv_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_i,
  input  logic [1:0]   op_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         ove_i,
  output logic         busy_o,
  output logic         done_o,
  output logic [W-1:0] result_o,
  output logic         wr_en_o,
  output logic         carry_o,
  output logic         ovf_o,
  output logic         range_exc_o
);
  localparam int unsigned PW = 2 * W;

  logic load, step, fin;
  md_op_e op_q, op_d;
  logic [W-1:0] a_q, a_d, b_q, b_d;
  logic ove_q, ove_d;

  logic [W-1:0] dvd_mag, dvs_mag, quo, quo_fix;
  logic [PW-1:0] uprod, sprod;
  logic sgn_div_in;

  logic [W-1:0] res_q, res_d;
  logic cy_q, cy_d, ov_q, ov_d, wr_q, wr_d, exc_q, exc_d;
  logic cy_n, ov_n, wr_n, exc_n;
  logic [W-1:0] res_n;
  logic div_zero, mul_cy, muls_ov;

  muldiv_ctrl #(.STEPS(W)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .busy_o(busy_o), .load_o(load), .step_o(step), .fin_o(fin), .done_o(done_o)
  );

  // Magnitudes feed the divider for signed divide; raw values otherwise.
  assign sgn_div_in = (md_op_e'(op_i) == OP_DIVS);
  assign dvd_mag = (sgn_div_in && a_i[W-1]) ? (~a_i + 1'b1) : a_i;
  assign dvs_mag = (sgn_div_in && b_i[W-1]) ? (~b_i + 1'b1) : b_i;

  muldiv_mul_engine #(.W(W)) mul_i (
    .clk(clk), .rst_n(rst_n), .load_i(load), .step_i(step),
    .mcand_i(a_i), .mplier_i(b_i), .prod_o(uprod)
  );

  muldiv_div_engine #(.W(W)) div_i (
    .clk(clk), .rst_n(rst_n), .load_i(load), .step_i(step),
    .dvd_i(dvd_mag), .dvs_i(dvs_mag), .quo_o(quo)
  );

  // Captured request (R12, R13): loaded only on the accepting edge.
  always_comb begin
    op_d  = op_q;
    a_d   = a_q;
    b_d   = b_q;
    ove_d = ove_q;
    if (load) begin
      op_d  = md_op_e'(op_i);
      a_d   = a_i;
      b_d   = b_i;
      ove_d = ove_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q  <= OP_MULS;
      a_q   <= '0;
      b_q   <= '0;
      ove_q <= 1'b0;
    end else if (load) begin
      op_q  <= op_d;
      a_q   <= a_d;
      b_q   <= b_d;
      ove_q <= ove_d;
    end
  end

  // Completion values per opcode (R1..R10).
  always_comb begin
    sprod = uprod
          - (a_q[W-1] ? {b_q, {W{1'b0}}} : {PW{1'b0}})
          - (b_q[W-1] ? {a_q, {W{1'b0}}} : {PW{1'b0}});
    mul_cy   = |uprod[PW-1:W];
    muls_ov  = (|sprod[PW-1:W-1]) && !(&sprod[PW-1:W-1]);
    div_zero = (b_q == '0);
    quo_fix  = ((op_q == OP_DIVS) && (a_q[W-1] ^ b_q[W-1])) ? (~quo + 1'b1) : quo;
    res_n = res_q;
    cy_n  = 1'b0;
    ov_n  = 1'b0;
    wr_n  = 1'b0;
    exc_n = 1'b0;
    unique case (op_q)
      OP_MULS: begin
        res_n = sprod[W-1:0];
        wr_n  = 1'b1;
        cy_n  = mul_cy;
        ov_n  = muls_ov;
        exc_n = ove_q && muls_ov;
      end
      OP_MULU: begin
        res_n = uprod[W-1:0];
        wr_n  = 1'b1;
        cy_n  = mul_cy;
      end
      default: begin
        cy_n  = div_zero;
        exc_n = ove_q && div_zero;
        if (!div_zero) begin
          res_n = quo_fix;
          wr_n  = 1'b1;
        end
      end
    endcase
  end

  always_comb begin
    res_d = res_q;
    cy_d  = cy_q;
    ov_d  = ov_q;
    wr_d  = 1'b0;
    exc_d = 1'b0;
    if (fin) begin
      res_d = res_n;
      cy_d  = cy_n;
      ov_d  = ov_n;
      wr_d  = wr_n;
      exc_d = exc_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q <= '0;
      cy_q  <= 1'b0;
      ov_q  <= 1'b0;
      wr_q  <= 1'b0;
      exc_q <= 1'b0;
    end else begin
      res_q <= res_d;
      cy_q  <= cy_d;
      ov_q  <= ov_d;
      wr_q  <= wr_d;
      exc_q <= exc_d;
    end
  end

  assign result_o    = res_q;
  assign carry_o     = cy_q;
  assign ovf_o       = ov_q;
  assign wr_en_o     = wr_q;
  assign range_exc_o = exc_q;
endmodule

// File: rtl/muldiv_unit_chk.sv
module muldiv_unit_chk
  import muldiv_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         busy_o,
  input logic         done_o,
  input logic         wr_en_o,
  input logic         carry_o,
  input logic         ovf_o,
  input logic         range_exc_o,
  input md_op_e       op_q,
  input logic [W-1:0] a_q,
  input logic [W-1:0] b_q
);
  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  p_wr_with_done_r1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_o |-> done_o);

  p_mulu_no_ovf_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && op_q == OP_MULU) |-> (!ovf_o && !range_exc_o));

  p_div_no_ovf_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && op_q[1]) |-> !ovf_o);

  p_div_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && op_q[1] && b_q == '0) |-> (carry_o && !wr_en_o));

  p_exc_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    range_exc_o |-> (done_o && (ovf_o || carry_o)));

  p_hold_request_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o)) |-> ($stable(a_q) && $stable(b_q) && $stable(op_q)));
endmodule

bind muldiv_unit muldiv_unit_chk #(.W(W)) chk_i (
  .clk(clk), .rst_n(rst_n), .busy_o(busy_o), .done_o(done_o),
  .wr_en_o(wr_en_o), .carry_o(carry_o), .ovf_o(ovf_o),
  .range_exc_o(range_exc_o), .op_q(op_q), .a_q(a_q), .b_q(b_q)
);

// File: tb/muldiv_unit_tb_top.sv
module muldiv_unit_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int W = 32;
  localparam int LAT = W + 2;

  typedef struct packed {
    logic [1:0]  op;
    logic [31:0] a;
    logic [31:0] b;
    logic        ove;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    '{2'b00, 32'd3,          32'd5,          1'b0},
    '{2'b00, 32'hFFFFFFF9,   32'd6,          1'b0},
    '{2'b00, 32'h00010000,   32'h00010000,   1'b1},
    '{2'b00, 32'h80000000,   32'hFFFFFFFF,   1'b0},
    '{2'b00, 32'h7FFFFFFF,   32'd1,          1'b1},
    '{2'b01, 32'hFFFFFFFF,   32'hFFFFFFFF,   1'b1},
    '{2'b01, 32'h00001234,   32'h00005678,   1'b1},
    '{2'b10, 32'hFFFFFFF9,   32'd2,          1'b0},
    '{2'b10, 32'd7,          32'hFFFFFFFE,   1'b0},
    '{2'b10, 32'hFFFFFF9C,   32'hFFFFFFF9,   1'b1},
    '{2'b11, 32'hFFFFFFFF,   32'h00000010,   1'b0},
    '{2'b11, 32'd100,        32'd0,          1'b1},
    '{2'b10, 32'd5,          32'd0,          1'b0},
    '{2'b11, 32'd3,          32'd7,          1'b1},
    '{2'b00, 32'hFFFFFFFF,   32'hFFFFFFFF,   1'b1}
  };

  logic        clk, rst_n, start_i, ove_i;
  logic [1:0]  op_i;
  logic [31:0] a_i, b_i, result_o;
  logic        busy_o, done_o, wr_en_o, carry_o, ovf_o, range_exc_o;

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;
  logic [31:0] last_res = '0;
  int lat_seen;

  muldiv_unit #(.W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i),
    .a_i(a_i), .b_i(b_i), .ove_i(ove_i), .busy_o(busy_o), .done_o(done_o),
    .result_o(result_o), .wr_en_o(wr_en_o), .carry_o(carry_o),
    .ovf_o(ovf_o), .range_exc_o(range_exc_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual %0d cycles, expected completion earlier", cyc);
        finish_run();
      end
    end
  end

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, got, exp);
    end
  endtask

  // Reference from the requirements, using 64-bit arithmetic.
  task automatic model(input vec_t v, input logic [31:0] prev,
                       output logic [31:0] res, output logic wr,
                       output logic cy, output logic ov, output logic exc);
    longint sp, sa, sb;
    logic [63:0] up;
    sa = longint'($signed(v.a));
    sb = longint'($signed(v.b));
    up = {32'b0, v.a} * {32'b0, v.b};
    res = prev; wr = 0; cy = 0; ov = 0; exc = 0;
    case (v.op)
      2'b00: begin
        sp  = sa * sb;
        res = sp[31:0]; wr = 1;
        ov  = (sp > 64'sd2147483647) || (sp < -64'sd2147483648);
        cy  = (up[63:32] != 0);
        exc = v.ove && ov;
      end
      2'b01: begin
        res = up[31:0]; wr = 1;
        cy  = (up[63:32] != 0);
      end
      default: begin
        if (v.b == 0) begin
          cy = 1; exc = v.ove;
        end else begin
          wr = 1;
          if (v.op == 2'b10) begin sp = sa / sb; res = sp[31:0]; end
          else res = v.a / v.b;
        end
      end
    endcase
  endtask

  // Issue one request and wait for done; lat_seen counts negedges from the accepting edge.
  task automatic run_op(input vec_t v);
    @(negedge clk);
    start_i = 1'b1; op_i = v.op; a_i = v.a; b_i = v.b; ove_i = v.ove;
    @(negedge clk);
    start_i = 1'b0;
    lat_seen = 1;
    while (!done_o && lat_seen < 100) begin
      @(negedge clk);
      lat_seen++;
    end
  endtask

  task automatic check_vec(input vec_t v);
    logic [31:0] er; logic ew, ec, eo, ee;
    model(v, last_res, er, ew, ec, eo, ee);
    run_op(v);
    check(v.op[1] ? "R6 result" : "R1 result", result_o, er);
    check(v.op[1] ? (v.b == 0 ? "R7 write" : "R6 write") : "R1 write", {31'b0, wr_en_o}, {31'b0, ew});
    check(v.op[1] ? "R7 carry" : (v.op[0] ? "R4 carry" : "R3 carry"), {31'b0, carry_o}, {31'b0, ec});
    check(v.op[1] ? "R8 overflow" : (v.op[0] ? "R4 overflow" : "R2 overflow"), {31'b0, ovf_o}, {31'b0, eo});
    check(v.op[1] ? "R9 range exc" : "R5 range exc", {31'b0, range_exc_o}, {31'b0, ee});
    check("R11 latency", lat_seen, LAT);
    last_res = er;
    @(negedge clk);
    check("R11 done width", {31'b0, done_o}, 32'd0);
  endtask

  initial begin
    rst_n = 1'b0; start_i = 1'b0; op_i = '0; a_i = '0; b_i = '0; ove_i = 1'b0;
    repeat (3) @(negedge clk);
    check("R11 reset busy", {31'b0, busy_o}, 0);
    check("R11 reset done", {31'b0, done_o}, 0);
    check("R11 reset result", result_o, 0);
    check("R11 reset flags", {28'b0, wr_en_o, carry_o, ovf_o, range_exc_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) check_vec(VECS[i]);

    // R10: most negative value divided by minus one.
    run_op('{2'b10, 32'h80000000, 32'hFFFFFFFF, 1'b1});
    check("R10 quotient", result_o, 32'h80000000);
    check("R10 flags", {29'b0, carry_o, ovf_o, range_exc_o}, 0);
    check("R10 write", {31'b0, wr_en_o}, 1);
    last_res = 32'h80000000;

    // R7: divide by zero right after a write keeps the old result.
    run_op('{2'b01, 32'd9, 32'd9, 1'b0});
    check("R1 setup write", result_o, 32'd81);
    run_op('{2'b10, 32'hFFFFFFFF, 32'd0, 1'b1});
    check("R7 result kept", result_o, 32'd81);
    check("R9 zero divisor exc", {31'b0, range_exc_o}, 1);

    // R12 and R13: conflicting request and enable change during busy.
    @(negedge clk);
    start_i = 1'b1; op_i = 2'b00; a_i = 32'h00020000; b_i = 32'h00020000; ove_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0; ove_i = 1'b0;
    repeat (5) @(negedge clk);
    check("R12 busy during run", {31'b0, busy_o}, 1);
    start_i = 1'b1; op_i = 2'b11; a_i = 32'd50; b_i = 32'd5;
    @(negedge clk);
    start_i = 1'b0;
    lat_seen = 7;
    while (!done_o && lat_seen < 100) begin
      @(negedge clk);
      lat_seen++;
    end
    check("R12 latency kept", lat_seen, LAT);
    check("R12 first result", result_o, 32'h0);
    check("R12 first overflow", {31'b0, ovf_o}, 1);
    check("R13 enable captured", {31'b0, range_exc_o}, 1);
    @(negedge clk);
    check("R12 no second run", {31'b0, busy_o}, 0);

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule